// File: doc/BRIEF.md
# Dual-Mode Host Bus Channel Decoder

This block sits between an external parallel host bus and four identical serial channels inside a device. Each channel holds eight byte-wide registers. A static strap input selects one of two bus styles. In the strobe style, the host uses separate active-low read and write strobes and one active-low select line per channel. In the direction style, the host uses one active-low chip select and one read/write level. In that style, two of the select pins are reused as high address bits that name the channel.

All bus pins pass through two-flop synchronizers into the internal clock domain. The block turns each host access into exactly one single-cycle read command or write command. With each command it gives the channel index, the register index and, for a write, the byte the host placed on the bus. During a valid read it drives the data bus with the byte that the addressed channel returns. At all other times it leaves the bus at high impedance. The channel register files connect to the command outputs and to the read-byte input.

Top module: `hbus_chan_decode`

## Requirements
- R1: After reset, `rd_pulse` and `wr_pulse` are 0, `chan_idx` and `reg_idx` are 0, and `bus_data` is not driven.
- R2: When `mode_strobe`=1, `rd_n` is low and exactly one `sel_n` bit is low, one `rd_pulse` is issued. `chan_idx` is the position of that low bit (`sel_n[0]`..`sel_n[3]` give 0..3) and `reg_idx` = `addr`. While `rd_n` stays low, `bus_data` carries `rd_byte`.
- R3: When `mode_strobe`=1, `wr_n` goes low and then high while exactly one `sel_n` bit is low. One `wr_pulse` is issued after the rise, with `wr_byte` equal to the bus byte held through the rise, and with the channel and register decoded as in R2.
- R4: When `mode_strobe`=1 and a strobe goes low while no `sel_n` bit is low, or while more than one is low, no pulse is issued and the bus is not driven.
- R5: When `mode_strobe`=1 and `rd_n` and `wr_n` go low together, the access is ignored: no pulse is issued and the bus is not driven.
- R6: When `mode_strobe`=0, `sel_n[0]` low with `wr_n`=1 (direction = read) gives one `rd_pulse`. `chan_idx` = {`sel_n[2]`,`sel_n[1]`}, `reg_idx` = `addr`, and `bus_data` carries `rd_byte` while `sel_n[0]` is low.
- R7: When `mode_strobe`=0, `sel_n[0]` low with `wr_n`=0 (direction = write) gives one `wr_pulse` after `sel_n[0]` rises, carrying the bus byte. If `wr_n` is back at 1 when `sel_n[0]` rises, neither a write nor a read is issued.
- R8: When `mode_strobe`=0, `rd_n` and `sel_n[3]` have no effect. Toggling `rd_n` while `sel_n[0]` is high issues no pulse, and `sel_n[3]` does not change the decoded channel.
- R9: Each access issues at most one pulse, and each pulse lasts one clock cycle. `rd_pulse` and `wr_pulse` are never high together.
- R10: `bus_data` is driven only from the start of a valid read until that read ends. It is released afterwards, and it is never driven during a write.
- R11: `chan_idx` and `reg_idx` are latched at the start of an access and held until it ends. A write commits to the register addressed when its strobe fell, even if `addr` changes before the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strobe | input | 1 | Bus style strap: 1 = strobe style, 0 = direction style |
| addr | input | ADDR_W (3) | Register index inside the channel |
| rd_n | input | 1 | Active-low read strobe (strobe style only) |
| wr_n | input | 1 | Active-low write strobe, or direction level (1 = read, 0 = write) |
| sel_n | input | 4 | Per-channel active-low selects; in direction style bit 0 is the chip select and bits 2:1 are the channel |
| bus_data | inout | DATA_W (8) | Host data bus |
| rd_byte | input | DATA_W (8) | Byte returned by the addressed channel register |
| chan_idx | output | 2 | Channel of the current or last access |
| reg_idx | output | ADDR_W (3) | Register of the current or last access |
| rd_pulse | output | 1 | One-cycle read command |
| wr_pulse | output | 1 | One-cycle write command |
| wr_byte | output | DATA_W (8) | Write data, valid with `wr_pulse` |

## Verification
Some properties are checked on every cycle. The read and write commands never overlap, and each lasts one cycle. Every read command coincides with the bus being driven, and no write command does. The latched channel and register stay fixed for as long as a read continues. Other behaviour can only be shown by the bench scenarios. These include the channel decoding in both bus styles, and the rejection of accesses with no select, several selects, or both strobes low. They also cover the cancelled direction-style write, the inert pins in direction style, and the return of the bus to high impedance after a read.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int NUM_CHAN = 4;
  localparam int CHAN_W   = $clog2(NUM_CHAN);
  localparam int REG_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } acc_state_t;

  // One decoded view of the synchronized bus pins for the current cycle
  typedef struct packed {
    logic              frame;   // an access is being framed by the host
    logic              ok;      // the framing access is well formed
    logic              is_rd;   // access direction is read
    logic              dir_wr;  // write direction currently asserted
    logic [CHAN_W-1:0] chan;    // decoded channel
    logic [REG_W-1:0]  reg_i;   // decoded register
  } bus_req_t;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int            W       = 8,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int ADDR_W = REG_W
) (
  input  logic                mode_strobe,
  input  logic                rd_n_s,
  input  logic                wr_n_s,
  input  logic [NUM_CHAN-1:0] sel_n_s,
  input  logic [ADDR_W-1:0]   addr_s,
  output bus_req_t            req
);

  localparam int CNT_W = $clog2(NUM_CHAN + 1);

  logic [CNT_W-1:0]  sel_cnt;
  logic [CHAN_W-1:0] sel_enc;

  // Count and encode the asserted per-channel selects
  always_comb begin
    sel_cnt = '0;
    sel_enc = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (!sel_n_s[i]) begin
        sel_cnt = sel_cnt + 1'b1;
        sel_enc = CHAN_W'(i);
      end
    end
  end

  always_comb begin
    req = '0;
    req.reg_i = REG_W'(addr_s);
    if (mode_strobe) begin
      req.frame  = !rd_n_s || !wr_n_s;
      req.ok     = (sel_cnt == CNT_W'(1)) && !(!rd_n_s && !wr_n_s);
      req.is_rd  = !rd_n_s;
      req.dir_wr = 1'b1;
      req.chan   = sel_enc;
    end else begin
      req.frame  = !sel_n_s[0];
      req.ok     = 1'b1;
      req.is_rd  = wr_n_s;
      req.dir_wr = !wr_n_s;
      req.chan   = {sel_n_s[2], sel_n_s[1]};
    end
  end

endmodule

// File: rtl/hbus_fsm.sv
module hbus_fsm
  import hbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_req_t          req,
  input  logic [DATA_W-1:0] data_s,
  output logic [CHAN_W-1:0] chan_idx,
  output logic [REG_W-1:0]  reg_idx,
  output logic              rd_pulse,
  output logic              wr_pulse,
  output logic [DATA_W-1:0] wr_byte,
  output logic              read_active
);

  acc_state_t        state_q, state_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic              rdp_q, rdp_d;
  logic              wrp_q, wrp_d;
  logic [DATA_W-1:0] wbyte_q, wbyte_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              capw_q, capw_d;
  logic              idx_en, cap_en, wbyte_en;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    rdp_d    = 1'b0;
    wrp_d    = 1'b0;
    idx_en   = 1'b0;
    cap_en   = 1'b0;
    wbyte_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req.frame) begin
          if (!req.ok) begin
            state_d = ST_HOLD;
          end else if (req.is_rd) begin
            state_d = ST_READ;
            rdp_d   = 1'b1;
            idx_en  = 1'b1;
          end else begin
            state_d = ST_WRITE;
            idx_en  = 1'b1;
            cap_en  = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (!req.frame) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        if (req.frame) begin
          cap_en = 1'b1;
        end else begin
          state_d  = ST_IDLE;
          wrp_d    = capw_q;
          wbyte_en = capw_q;
        end
      end
      ST_HOLD: begin
        if (!req.frame) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign chan_d  = idx_en   ? req.chan   : chan_q;
  assign reg_d   = idx_en   ? req.reg_i  : reg_q;
  assign cap_d   = cap_en   ? data_s     : cap_q;
  assign capw_d  = cap_en   ? req.dir_wr : capw_q;
  assign wbyte_d = wbyte_en ? cap_q      : wbyte_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      reg_q   <= '0;
      rdp_q   <= 1'b0;
      wrp_q   <= 1'b0;
      wbyte_q <= '0;
      cap_q   <= '0;
      capw_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      reg_q   <= reg_d;
      rdp_q   <= rdp_d;
      wrp_q   <= wrp_d;
      wbyte_q <= wbyte_d;
      cap_q   <= cap_d;
      capw_q  <= capw_d;
    end
  end

  assign chan_idx    = chan_q;
  assign reg_idx     = reg_q;
  assign rd_pulse    = rdp_q;
  assign wr_pulse    = wrp_q;
  assign wr_byte     = wbyte_q;
  assign read_active = (state_q == ST_READ);

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdp_q && wrp_q));

  assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdp_q |=> !rdp_q);

  assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrp_q |=> !wrp_q);

  assert_hold_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && $past(state_q) == ST_READ) |-> ($stable(chan_q) && $stable(reg_q)));

endmodule

// File: rtl/hbus_chan_decode.sv
module hbus_chan_decode
  import hbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [NUM_CHAN-1:0] sel_n,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [CHAN_W-1:0] chan_idx,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              rd_pulse,
  output logic              wr_pulse,
  output logic [DATA_W-1:0] wr_byte
);

  localparam int SYNC_W = ADDR_W + 2 + NUM_CHAN + DATA_W;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s_q;

  logic [SYNC_W-1:0]   pins_async, pins_sync;
  logic [ADDR_W-1:0]   addr_s;
  logic                rd_n_s, wr_n_s;
  logic [NUM_CHAN-1:0] sel_n_s;
  logic [DATA_W-1:0]   data_s;

  assign pins_async = {addr, rd_n, wr_n, sel_n, bus_data};

  hbus_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({SYNC_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async (pins_async),
    .q_sync  (pins_sync)
  );

  assign {addr_s, rd_n_s, wr_n_s, sel_n_s, data_s} = pins_sync;

  bus_req_t req;

  hbus_decode #(
    .ADDR_W (ADDR_W)
  ) u_decode (
    .mode_strobe (mode_strobe),
    .rd_n_s      (rd_n_s),
    .wr_n_s      (wr_n_s),
    .sel_n_s     (sel_n_s),
    .addr_s      (addr_s),
    .req         (req)
  );

  logic [REG_W-1:0] reg_i;
  logic             drive_en;

  hbus_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req         (req),
    .data_s      (data_s),
    .chan_idx    (chan_idx),
    .reg_idx     (reg_i),
    .rd_pulse    (rd_pulse),
    .wr_pulse    (wr_pulse),
    .wr_byte     (wr_byte),
    .read_active (drive_en)
  );

  assign reg_idx  = ADDR_W'(reg_i);
  assign bus_data = drive_en ? rd_byte : {DATA_W{1'bz}};

  assert_drive_on_read_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_pulse |-> drive_en);

  assert_quiet_on_write_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_pulse |-> !drive_en);

endmodule

// File: tb/sim_hbus_chan_decode.sv
`timescale 1ns/1ps
module sim_hbus_chan_decode;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_strobe;
  logic [2:0] addr;
  logic       rd_n, wr_n;
  logic [3:0] sel_n;
  wire  [7:0] bus_data;
  logic [7:0] rd_byte;
  logic [1:0] chan_idx;
  logic [2:0] reg_idx;
  logic       rd_pulse, wr_pulse;
  logic [7:0] wr_byte;
  logic       host_en;
  logic [7:0] host_val;

  always #2.5 clk = ~clk;

  assign bus_data = host_en ? host_val : 8'hzz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (bus_data[i]);
  end

  // Register file stub: a byte derived from channel and register
  assign rd_byte = {chan_idx, 3'b101, reg_idx};

  hbus_chan_decode u0 (
    .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .sel_n(sel_n), .bus_data(bus_data),
    .rd_byte(rd_byte), .chan_idx(chan_idx), .reg_idx(reg_idx),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .wr_byte(wr_byte)
  );

  int tests = 0;
  int fails = 0;
  int mon_rd = 0, mon_wr = 0;
  logic [1:0] m_chan;
  logic [2:0] m_reg;
  logic [7:0] m_byte;

  always @(posedge clk) begin
    if (rd_pulse) begin
      mon_rd <= mon_rd + 1;
      m_chan <= chan_idx;
      m_reg  <= reg_idx;
    end
    if (wr_pulse) begin
      mon_wr <= mon_wr + 1;
      m_chan <= chan_idx;
      m_reg  <= reg_idx;
      m_byte <= wr_byte;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    rd_n = 1'b1; wr_n = 1'b1; sel_n = 4'b1111; host_en = 1'b0;
  endtask

  // Fields: mode, is_wr, sel_n, addr, data, expect_ok, expect_chan
  localparam int NV = 10;
  localparam logic [19:0] VECS [NV] = '{
    {1'b1, 1'b0, 4'b1110, 3'd3, 8'h00, 1'b1, 2'd0},
    {1'b1, 1'b0, 4'b1011, 3'd5, 8'h00, 1'b1, 2'd2},
    {1'b1, 1'b1, 4'b1101, 3'd1, 8'h3C, 1'b1, 2'd1},
    {1'b1, 1'b1, 4'b0111, 3'd7, 8'hA5, 1'b1, 2'd3},
    {1'b1, 1'b0, 4'b1100, 3'd2, 8'h00, 1'b0, 2'd0},
    {1'b1, 1'b1, 4'b1111, 3'd6, 8'h77, 1'b0, 2'd0},
    {1'b0, 1'b0, 4'b1100, 3'd4, 8'h00, 1'b1, 2'd2},
    {1'b0, 1'b1, 4'b1110, 3'd2, 8'h5A, 1'b1, 2'd3},
    {1'b0, 1'b1, 4'b0000, 3'd0, 8'hC3, 1'b1, 2'd0},
    {1'b0, 1'b0, 4'b0010, 3'd6, 8'h00, 1'b1, 2'd1}
  };

  task automatic access(input bit md, input bit is_wr, input logic [3:0] sel,
                        input logic [2:0] a, input logic [7:0] d,
                        input bit exp_ok, input logic [1:0] exp_ch,
                        input bit flip_dir, input bit move_addr, input string req);
    int base_rd, base_wr;
    bit exp_w, exp_r;
    base_rd = mon_rd; base_wr = mon_wr;
    @(negedge clk);
    mode_strobe = md; addr = a;
    if (is_wr) begin host_en = 1'b1; host_val = d; end
    if (md) sel_n = sel;
    else begin sel_n = sel | 4'b0001; wr_n = !is_wr; end
    repeat (3) @(negedge clk);
    if (md) begin
      if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    end else sel_n[0] = 1'b0;
    repeat (4) @(negedge clk);
    if (move_addr) addr = ~a;
    repeat (4) @(negedge clk);
    if (!is_wr)
      chk(bus_data == (exp_ok ? {exp_ch, 3'b101, a} : 8'hFF), {req, " bus during read"},
          32'(bus_data), exp_ok ? 32'({exp_ch, 3'b101, a}) : 32'hFF);
    if (flip_dir) begin wr_n = 1'b1; repeat (4) @(negedge clk); end
    if (md) begin rd_n = 1'b1; wr_n = 1'b1; end
    else sel_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins();
    repeat (6) @(negedge clk);
    exp_w = exp_ok && is_wr && !flip_dir;
    exp_r = exp_ok && !is_wr;
    chk(mon_rd - base_rd == int'(exp_r), {req, " read pulses"}, 32'(mon_rd - base_rd), 32'(exp_r));
    chk(mon_wr - base_wr == int'(exp_w), {req, " write pulses"}, 32'(mon_wr - base_wr), 32'(exp_w));
    if (exp_r || exp_w) begin
      chk(m_chan == exp_ch, {req, " channel"}, 32'(m_chan), 32'(exp_ch));
      chk(m_reg == a, {req, " register R11"}, 32'(m_reg), 32'(a));
    end
    if (exp_w) chk(m_byte == d, {req, " write byte"}, 32'(m_byte), 32'(d));
    chk(bus_data == 8'hFF, "R10 bus released", 32'(bus_data), 32'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0; mode_strobe = 1'b1; addr = 3'd0; host_val = 8'h00;
    idle_pins();
    repeat (4) @(negedge clk);
    chk(rd_pulse == 0 && wr_pulse == 0, "R1 pulses in reset", 32'({rd_pulse, wr_pulse}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_pulse == 0 && wr_pulse == 0, "R1 pulses idle", 32'({rd_pulse, wr_pulse}), 0);
    chk(chan_idx == 0 && reg_idx == 0, "R1 indices", 32'({chan_idx, reg_idx}), 0);
    chk(bus_data == 8'hFF, "R1 bus released", 32'(bus_data), 32'hFF);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v][19]) tag = VECS[v][18] ? "R3 R9" : (VECS[v][2] ? "R2 R9" : "R4");
      else             tag = VECS[v][18] ? "R7 R8" : "R6 R8";
      if (VECS[v][19] && VECS[v][18] && !VECS[v][2]) tag = "R4 write";
      access(VECS[v][19], VECS[v][18], VECS[v][17:14], VECS[v][13:11], VECS[v][10:3],
             VECS[v][2], VECS[v][1:0], 1'b0, 1'b0, tag);
    end

    // R11: address moves while the write strobe is low
    access(1'b1, 1'b1, 4'b1011, 3'd2, 8'h96, 1'b1, 2'd2, 1'b0, 1'b1, "R11 moved addr");
    // R7: direction returns to read before the select rises
    access(1'b0, 1'b1, 4'b1010, 3'd3, 8'h11, 1'b1, 2'd1, 1'b1, 1'b0, "R7 cancelled");

    // R5: both strobes fall together
    begin
      int br, bw;
      br = mon_rd; bw = mon_wr;
      @(negedge clk); mode_strobe = 1'b1; sel_n = 4'b1110; addr = 3'd1;
      repeat (3) @(negedge clk); rd_n = 1'b0; wr_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(bus_data == 8'hFF, "R5 bus not driven", 32'(bus_data), 32'hFF);
      rd_n = 1'b1; wr_n = 1'b1;
      repeat (4) @(negedge clk); idle_pins(); repeat (6) @(negedge clk);
      chk(mon_rd == br && mon_wr == bw, "R5 no pulse", 32'(mon_rd - br + mon_wr - bw), 0);
    end

    // R8: read strobe toggles in direction style with the select high
    begin
      int br, bw;
      br = mon_rd; bw = mon_wr;
      @(negedge clk); mode_strobe = 1'b0;
      for (int k = 0; k < 3; k++) begin
        rd_n = 1'b0; repeat (5) @(negedge clk);
        rd_n = 1'b1; repeat (5) @(negedge clk);
      end
      chk(mon_rd == br && mon_wr == bw, "R8 read strobe inert", 32'(mon_rd - br + mon_wr - bw), 0);
      chk(bus_data == 8'hFF, "R8 bus not driven", 32'(bus_data), 32'hFF);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule